// File: doc/BRIEF.md
# I2C digipot register interface

This block is the serial front end of a 128-position digital potentiometer. It listens on an I2C bus through SCL and SDA samples that are already synchronised to the system clock. It drives SDA low through a single open-drain pull-down enable. The block owns the 7-bit wiper register and a 7-bit copy of the persistent setting. A separate store controller handles the slow non-volatile programming. The block sends that controller a one-cycle request and gets a busy flag back.

Registers are reached indirectly. A pointer transaction (register address 02h, then a select byte) chooses whether later accesses at register address 00h go to the wiper or to the persistent setting. A second device-type code starts a streaming mode. In that mode every SCL clock moves the wiper one step up or down, and the wiper stops at either end of its range. While the store controller is busy the bus is ignored, so a master can poll for completion by checking whether its address is acknowledged.

Top module: `digipot_i2c_slave`

## Requirements
- R1: After reset the wiper holds 64, the pointer selects the wiper, `sda_pd` is low and `store_req` is low.
- R2: A slave byte is acknowledged only when bits [7:3] are 01010 (or 01011 for write only) and bits [2:1] equal `strap`. Bit 0 set to 1 means read. Any other slave byte gets no ACK.
- R3: A write to register address 02h followed by a select byte of 80h points at the wiper, and 00h points at the persistent setting. Both are acknowledged. Any other select byte is not acknowledged and leaves the pointer unchanged.
- R4: When the wiper is selected, a write of register address 00h and a data byte stores data bits [6:0] in the wiper at the ACK of the data byte. Bit 7 is ignored.
- R5: When the persistent setting is selected, the data byte changes nothing until STOP. On STOP the block raises `store_req` for one cycle with `store_data` equal to data bits [6:0], and loads that value into both the wiper and the persistent copy.
- R6: A read is a write-mode slave byte, register address 00h, a repeated START and a read-mode slave byte. The block then sends the selected register with bit 7 at 0. It repeats the byte while the master ACKs. After a NACK it keeps SDA released until the next START or STOP.
- R7: A read-mode slave byte is not acknowledged unless register address 00h was accepted earlier in the same transaction. The pointer register therefore cannot be read.
- R8: After slave type 01011 and register address 00h, each SCL rising edge with SDA high raises the wiper by one, and each with SDA low lowers it by one. This includes the rising edge that precedes STOP.
- R9: In the stepping mode the wiper stays at 127 when stepped up and at 0 when stepped down. It never wraps.
- R10: While `store_busy` is high the block does not acknowledge, keeps SDA released and changes no register.
- R11: A START or STOP in the middle of a byte abandons the transfer. A data byte cut short this way changes nothing, and the next transaction is decoded from its slave byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Synchronised SCL sample |
| sda_i | input | 1 | Synchronised SDA sample (wired-AND bus value) |
| strap | input | 2 | Pin-strapped slave address bits |
| store_busy | input | 1 | Store controller is programming |
| sda_pd | output | 1 | Pull SDA low when high |
| store_req | output | 1 | One-cycle request to store `store_data` |
| store_data | output | 7 | Value to make persistent |
| wiper | output | 7 | Current wiper position |

## Verification
Every result is registered on the clock after the SCL or SDA sample that causes it. An ACK or a transmitted bit appears one cycle after the SCL falling edge that opens its slot. A wiper step appears one cycle after the SCL rising edge. A store request appears one cycle after STOP is seen. The bench moves the bus only on falling clock edges and holds each SCL phase for several cycles. It reads SDA in the middle of the SCL high phase, and it checks registers only after the quarter-period that follows the edge in question. So each result has settled well before it is sampled and no check can straddle an update.

// File: rtl/digipot_i2c_slave.sv
module digipot_i2c_slave (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap,
  input  logic       store_busy,
  output logic       sda_pd,
  output logic       store_req,
  output logic [6:0] store_data,
  output logic [6:0] wiper
);

  localparam logic [4:0] TYPE_RW   = 5'b01010;
  localparam logic [4:0] TYPE_STEP = 5'b01011;
  localparam logic [7:0] ADDR_PTR  = 8'h02;
  localparam logic [7:0] ADDR_REG  = 8'h00;
  localparam logic [7:0] PICK_WIP  = 8'h80;
  localparam logic [7:0] PICK_NV   = 8'h00;
  localparam logic [6:0] MIDSCALE  = 7'd64;
  localparam logic [6:0] TOP       = 7'd127;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_RACK, S_RACKD, S_STEP} st_t;
  typedef enum logic [1:0] {P_SLAVE, P_ADDR, P_SEL, P_DATA} ph_t;

  st_t        st, after;
  ph_t        ph;
  logic       scl_q, sda_q;
  logic [7:0] sh, tx;
  logic [3:0] cnt;
  logic       sel_nv, step_mode, reg_ok, pend;
  logic [6:0] pend_val, nv_q;

  logic rise, fall, start_c, stop_c, slave_hit;
  logic [6:0] sel_val;

  assign rise      = ~scl_q & scl_i;
  assign fall      = scl_q & ~scl_i;
  assign start_c   = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_c    = scl_q & scl_i & ~sda_q & sda_i;
  assign slave_hit = (sh[2:1] == strap) &&
                     (sh[7:3] == TYPE_RW || (sh[7:3] == TYPE_STEP && !sh[0]));
  assign sel_val   = sel_nv ? nv_q : wiper;
  assign sda_pd    = ~store_busy & ((st == S_ACK) | ((st == S_TX) & ~tx[7]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; after <= S_IDLE; ph <= P_SLAVE;
      scl_q <= 1'b1; sda_q <= 1'b1;
      sh <= '0; tx <= '0; cnt <= '0;
      sel_nv <= 1'b0; step_mode <= 1'b0; reg_ok <= 1'b0; pend <= 1'b0;
      pend_val <= '0; nv_q <= MIDSCALE; wiper <= MIDSCALE;
      store_req <= 1'b0; store_data <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      store_req <= 1'b0;
      if (store_busy) begin
        st <= S_IDLE;
      end else if (start_c) begin
        st <= S_RX; ph <= P_SLAVE; cnt <= '0; pend <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; reg_ok <= 1'b0;
        if (pend) begin
          store_req <= 1'b1; store_data <= pend_val;
          nv_q <= pend_val; wiper <= pend_val; pend <= 1'b0;
        end
      end else begin
        case (st)
          S_RX:
            if (rise && cnt != 4'd8) begin
              sh  <= {sh[6:0], sda_i};
              cnt <= cnt + 4'd1;
            end else if (fall && cnt == 4'd8) begin
              st  <= S_IDLE;
              cnt <= '0;
              case (ph)
                P_SLAVE:
                  if (slave_hit) begin
                    step_mode <= sh[3];
                    if (!sh[0]) begin
                      st <= S_ACK; after <= S_RX; ph <= P_ADDR; reg_ok <= 1'b0;
                    end else if (reg_ok) begin
                      st <= S_ACK; after <= S_TX;
                    end
                  end
                P_ADDR:
                  if (sh == ADDR_REG) begin
                    st <= S_ACK;
                    if (step_mode) after <= S_STEP;
                    else begin after <= S_RX; ph <= P_DATA; reg_ok <= 1'b1; end
                  end else if (sh == ADDR_PTR && !step_mode) begin
                    st <= S_ACK; after <= S_RX; ph <= P_SEL;
                  end
                P_SEL:
                  if (sh == PICK_WIP || sh == PICK_NV) begin
                    sel_nv <= (sh == PICK_NV);
                    st <= S_ACK; after <= S_IDLE;
                  end
                P_DATA: begin
                  st <= S_ACK; after <= S_IDLE;
                  if (sel_nv) begin pend <= 1'b1; pend_val <= sh[6:0]; end
                  else wiper <= sh[6:0];
                end
                default: ;
              endcase
            end
          S_ACK:
            if (fall) begin
              st  <= after;
              cnt <= '0;
              if (after == S_TX) tx <= {1'b0, sel_val};
            end
          S_TX:
            if (fall) begin
              if (cnt == 4'd7) st <= S_RACK;
              else begin tx <= {tx[6:0], 1'b0}; cnt <= cnt + 4'd1; end
            end
          S_RACK:
            if (rise) st <= sda_i ? S_IDLE : S_RACKD;
          S_RACKD:
            if (fall) begin st <= S_TX; cnt <= '0; tx <= {1'b0, sel_val}; end
          S_STEP:
            if (rise) begin
              if (sda_i && wiper != TOP) wiper <= wiper + 7'd1;
              else if (!sda_i && wiper != 7'd0) wiper <= wiper - 7'd1;
            end
          default: ;
        endcase
      end
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |=> !store_req); // R5
  AST_REQ_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |-> $past(stop_c)); // R5
  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    store_busy |=> (!store_req && $stable(wiper))); // R10
  AST_TX_MSB_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TX && cnt == 4'd0 && !store_busy) |-> sda_pd); // R6
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STEP && $past(st) == S_STEP) |->
      (7'(wiper - $past(wiper)) inside {7'd0, 7'd1, 7'd127})); // R8
  AST_STEP_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STEP && $past(st) == S_STEP && $past(wiper) == TOP) |-> wiper != 7'd0); // R9

endmodule

// File: tb/sim_digipot_i2c_slave.sv
module sim_digipot_i2c_slave;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, m_sda = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sda_pd, store_req, store_busy;
  logic [6:0] store_data, wiper;
  logic line;
  int nchk = 0, nfail = 0, nreq = 0, busy_cnt = 0;
  logic [6:0] last_data = '0;

  assign line = m_sda & ~sda_pd;
  assign store_busy = (busy_cnt != 0);

  always #2 clk = ~clk;

  digipot_i2c_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line), .strap(strap),
    .store_busy(store_busy), .sda_pd(sda_pd), .store_req(store_req),
    .store_data(store_data), .wiper(wiper));

  always @(posedge clk) begin
    if (store_req) begin busy_cnt <= 300; nreq <= nreq + 1; last_data <= store_data; end
    else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
  end

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic q; repeat (5) @(negedge clk); endtask
  task automatic bus_start; m_sda = 1; q; scl = 1; q; m_sda = 0; q; scl = 0; q; endtask
  task automatic bus_stop;  m_sda = 0; q; scl = 1; q; m_sda = 1; q; endtask
  task automatic send_bit(input logic b); m_sda = b; q; scl = 1; q; q; scl = 0; q; endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1; q; scl = 1; q; ack = ~line; q; scl = 0; q;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic ack);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      m_sda = 1; q; scl = 1; q; b = {b[6:0], line}; q; scl = 0; q;
    end
    m_sda = ~ack; q; scl = 1; q; q; scl = 0; q;
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d, input string req);
    logic k;
    bus_start;
    send_byte(8'h54, k); check(req, k, 1);
    send_byte(a, k);     check(req, k, 1);
    send_byte(d, k);     check(req, k, 1);
    bus_stop;
  endtask

  task automatic t_reset;
    check("R1 wiper", wiper, 64);
    check("R1 sda_pd", sda_pd, 0);
    check("R1 store_req", store_req, 0);
    reg_write(8'h00, 8'h05, "R1 default pointer ack");
    check("R1 pointer selects wiper", wiper, 7'h05);
  endtask

  task automatic t_address;
    logic k;
    bus_start; send_byte(8'h52, k); check("R2 wrong strap nack", k, 0); bus_stop;
    bus_start; send_byte(8'h74, k); check("R2 wrong type nack", k, 0); bus_stop;
  endtask

  task automatic t_volatile;
    logic k;
    reg_write(8'h02, 8'h80, "R3 select wiper ack");
    bus_start; send_byte(8'h54, k); send_byte(8'h00, k); send_byte(8'h35, k);
    check("R4 data ack", k, 1);
    check("R4 wiper at data ack", wiper, 7'h35);
    bus_stop;
    reg_write(8'h00, 8'hC6, "R4 write ack");
    check("R4 msb ignored", wiper, 7'h46);
  endtask

  task automatic t_read(input logic [6:0] exp, input string req);
    logic k; logic [7:0] b;
    bus_start; send_byte(8'h54, k); send_byte(8'h00, k);
    bus_start; send_byte(8'h55, k); check({req, " read addr ack"}, k, 1);
    recv_byte(b, 1'b1); check({req, " first byte"}, b, {1'b0, exp});
    recv_byte(b, 1'b0); check({req, " repeated byte"}, b, {1'b0, exp});
    recv_byte(b, 1'b1); check({req, " released after nack"}, b, 8'hFF);
    bus_stop;
  endtask

  task automatic t_read_guard;
    logic k;
    bus_start; send_byte(8'h55, k); check("R7 bare read nack", k, 0); bus_stop;
    bus_start; send_byte(8'h54, k); send_byte(8'h02, k);
    bus_start; send_byte(8'h55, k); check("R7 pointer read nack", k, 0); bus_stop;
  endtask

  task automatic t_bad_select;
    logic k;
    bus_start; send_byte(8'h54, k); send_byte(8'h02, k); send_byte(8'h40, k);
    check("R3 bad select nack", k, 0); bus_stop;
    reg_write(8'h00, 8'h11, "R3 write after bad select");
    check("R3 pointer kept", wiper, 7'h11);
  endtask

  task automatic t_persist;
    logic k;
    reg_write(8'h02, 8'h00, "R3 select persistent ack");
    bus_start; send_byte(8'h54, k); send_byte(8'h00, k); send_byte(8'h93, k);
    check("R5 data ack", k, 1);
    check("R5 wiper held before stop", wiper, 7'h11);
    check("R5 no request before stop", nreq, 0);
    bus_stop;
    check("R5 one request", nreq, 1);
    check("R5 store data", last_data, 7'h13);
    check("R5 wiper on stop", wiper, 7'h13);
  endtask

  task automatic t_busy;
    logic k;
    bus_start; send_byte(8'h54, k); check("R10 busy nack", k, 0); bus_stop;
    check("R10 still busy", store_busy, 1);
    wait (!store_busy); q;
    bus_start; send_byte(8'h54, k); check("R10 ack after busy", k, 1); bus_stop;
  endtask

  task automatic t_step;
    logic k;
    reg_write(8'h02, 8'h80, "R3 reselect wiper");
    reg_write(8'h00, 8'h7D, "R8 preset");
    bus_start; send_byte(8'h5C, k); check("R8 step slave ack", k, 1);
    send_byte(8'h00, k); check("R8 step addr ack", k, 1);
    send_bit(1); check("R8 step up", wiper, 7'h7E);
    for (int i = 0; i < 4; i++) send_bit(1);
    check("R9 ceiling", wiper, 7'h7F);
    for (int i = 0; i < 3; i++) send_bit(0);
    check("R8 step down", wiper, 7'h7C);
    bus_stop;
    check("R8 stop clock steps and value kept", wiper, 7'h7B);
    reg_write(8'h00, 8'h02, "R9 preset");
    bus_start; send_byte(8'h5C, k); send_byte(8'h00, k);
    for (int i = 0; i < 4; i++) send_bit(0);
    check("R9 floor", wiper, 7'h00);
    bus_stop;
    check("R9 floor after stop", wiper, 7'h00);
  endtask

  task automatic t_abort;
    logic k;
    bus_start; send_bit(0); send_bit(1); send_bit(0); send_bit(1);
    bus_start; send_byte(8'h54, k); check("R11 restart decodes slave", k, 1);
    send_byte(8'h00, k); send_byte(8'h22, k); bus_stop;
    check("R11 write after restart", wiper, 7'h22);
    bus_start; send_byte(8'h54, k); send_byte(8'h00, k);
    send_bit(0); send_bit(1); send_bit(1); send_bit(1);
    bus_stop;
    check("R11 cut data byte ignored", wiper, 7'h22);
    check("R11 sda released", sda_pd, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_address;
    t_volatile;
    t_read(7'h46, "R6 wiper");
    t_read_guard;
    t_bad_select;
    t_persist;
    t_busy;
    t_read(7'h13, "R6 persistent");
    check("R6 read leaves wiper", wiper, 7'h13);
    t_step;
    t_abort;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule